// File: doc/BRIEF.md
# Counting-Pattern Stream Checker

This block receives one AXI4-Stream packet at a time and checks it. The packet is expected to have passed unchanged through some other logic after being generated as a plain counting sequence. Software or a test sequencer first gives the packet length, in beats, and pulses an arm strobe. The checker then accepts beats and compares each data word with a running count. The count is zero on the first beat and goes up by one on each beat accepted. The checker also requires tlast on the last beat of the programmed length, and on no other beat.

When the last beat has been taken, the checker stops accepting data and raises a one-cycle completion pulse. Any mismatch in data or tlast placement sets a flag that stays high until the next arm. A new arm during a packet abandons that packet and starts the count again at zero. Nothing inside the packet is decoded as a header.

Top module: `stream_seq_checker`

## Requirements
- R1: After reset, s_tready, done_o and fail_o are all low.
- R2: An arm strobe with a nonzero pkt_len_i drives s_tready high from the cycle after the strobe. An arm with pkt_len_i equal to 0 is ignored: s_tready and fail_o keep their values.
- R3: A beat is accepted when s_tvalid and s_tready are both high. Its data must equal the number of beats accepted before it since the arm: 0 for the first beat, then 1, 2 and so on. A mismatch sets fail_o in the cycle after that beat.
- R4: Cycles with s_tvalid low neither advance the count nor raise fail_o.
- R5: tlast high on any accepted beat whose index is below pkt_len_i minus 1 sets fail_o.
- R6: tlast low on the accepted beat whose index equals pkt_len_i minus 1 sets fail_o.
- R7: s_tready goes low in the cycle after the final beat is accepted. Beats offered after that are not consumed and do not change fail_o.
- R8: done_o is high for exactly one cycle, the cycle after the final beat is accepted, whether or not the packet was correct.
- R9: fail_o stays high until the next valid arm strobe, and that strobe clears it in the following cycle.
- R10: With a length of 1, one beat carrying data 0 with tlast high completes the packet without failure.
- R11: An arm strobe while a packet is in progress restarts the count at zero with the new length. A beat presented in the same cycle as that strobe is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | One-cycle strobe that starts checking one packet |
| pkt_len_i | input | LEN_W | Expected packet length in beats, sampled with arm_i |
| s_tdata | input | DATA_W | Stream data |
| s_tvalid | input | 1 | Stream valid |
| s_tlast | input | 1 | Stream end-of-packet marker |
| s_tready | output | 1 | Stream ready, high while a packet is expected |
| done_o | output | 1 | One-cycle pulse after the final beat |
| fail_o | output | 1 | Sticky mismatch flag |

## Verification
The bench builds the checker with 64-bit data, a 64-bit beat counter and an 8-bit length port. That keeps the widest possible packet, 255 beats, short enough to run in full, so the last-index compare is exercised at the top of the length range. Lengths of 0, 1 and several small values reach the edge cases: an ignored arm, a single-beat packet, tlast arriving early or missing, and a restart part-way through a packet. A behavioural model is compared with the ready, done and fail outputs on every clock, across idle gaps and beats offered while not ready.

// File: rtl/stream_chk_pkg.sv
package stream_chk_pkg;

  typedef struct packed {
    logic data_bad;
    logic last_bad;
  } beat_verdict_t;

  function automatic logic verdict_bad(input beat_verdict_t v);
    return v.data_bad | v.last_bad;
  endfunction

endpackage

// File: rtl/stream_chk_tracker.sv
module stream_chk_tracker #(
  parameter int LEN_W = 32,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_ok,
  input  logic [LEN_W-1:0] len,
  input  logic             beat_ok,
  output logic             armed_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             is_final_o
);

  logic [CNT_W-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_o  <= 1'b0;
      idx_o    <= '0;
      last_idx <= '0;
    end else if (arm_ok) begin
      armed_o  <= 1'b1;
      idx_o    <= '0;
      last_idx <= CNT_W'(len) - CNT_W'(1);
    end else if (beat_ok) begin
      idx_o <= idx_o + CNT_W'(1);
      if (is_final_o) armed_o <= 1'b0;
    end
  end

  assign is_final_o = (idx_o == last_idx);

  // R7: the final accepted beat closes the packet
  a_r7_ready_drops: assert property (@(posedge clk) disable iff (rst)
    beat_ok && is_final_o |=> !armed_o);

  // R4: no accepted beat, no arm -> index holds
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !beat_ok && !arm_ok |=> $stable(idx_o));

endmodule

// File: rtl/stream_chk_compare.sv
module stream_chk_compare
  import stream_chk_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 64
) (
  input  logic [DATA_W-1:0] beat_data,
  input  logic              beat_last,
  input  logic [CNT_W-1:0]  idx,
  input  logic              is_final,
  output beat_verdict_t     verdict
);

  logic [DATA_W-1:0] expected;

  assign expected         = DATA_W'(idx);
  assign verdict.data_bad = (beat_data != expected);
  assign verdict.last_bad = (beat_last != is_final);

endmodule

// File: rtl/stream_chk_result.sv
module stream_chk_result
  import stream_chk_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          arm_ok,
  input  logic          beat_ok,
  input  logic          is_final,
  input  beat_verdict_t verdict,
  output logic          done_o,
  output logic          fail_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      done_o <= beat_ok && is_final;
      if (arm_ok)
        fail_o <= 1'b0;
      else if (beat_ok && verdict_bad(verdict))
        fail_o <= 1'b1;
    end
  end

  // R9: flag persists until a valid arm
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    fail_o && !arm_ok |=> fail_o);

  // R9: a valid arm clears the flag
  a_r9_arm_clears: assert property (@(posedge clk) disable iff (rst)
    arm_ok |=> !fail_o);

endmodule

// File: rtl/stream_seq_checker.sv
module stream_seq_checker
  import stream_chk_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  input  logic              s_tlast,
  output logic              s_tready,
  output logic              done_o,
  output logic              fail_o
);

  logic             arm_ok;
  logic             beat_ok;
  logic [CNT_W-1:0] idx;
  logic             is_final;
  beat_verdict_t    verdict;

  assign arm_ok  = arm_i && (pkt_len_i != '0);
  assign beat_ok = s_tvalid && s_tready && !arm_ok;

  stream_chk_tracker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_tracker (
    .clk        (clk),
    .rst        (rst),
    .arm_ok     (arm_ok),
    .len        (pkt_len_i),
    .beat_ok    (beat_ok),
    .armed_o    (s_tready),
    .idx_o      (idx),
    .is_final_o (is_final)
  );

  stream_chk_compare #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_compare (
    .beat_data (s_tdata),
    .beat_last (s_tlast),
    .idx       (idx),
    .is_final  (is_final),
    .verdict   (verdict)
  );

  stream_chk_result u_result (
    .clk      (clk),
    .rst      (rst),
    .arm_ok   (arm_ok),
    .beat_ok  (beat_ok),
    .is_final (is_final),
    .verdict  (verdict),
    .done_o   (done_o),
    .fail_o   (fail_o)
  );

  // R2: zero-length arm leaves an idle checker idle
  a_r2_zero_ignored: assert property (@(posedge clk) disable iff (rst)
    arm_i && (pkt_len_i == '0) && !s_tready |=> !s_tready);

  // R8: completion never lasts two cycles
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: tb/stream_seq_checker_bench.sv
`timescale 1ns/1ps
module stream_seq_checker_bench;

  localparam int DATA_W = 64;
  localparam int LEN_W  = 8;
  localparam int CNT_W  = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              arm_i = 1'b0;
  logic [LEN_W-1:0]  pkt_len_i = '0;
  logic [DATA_W-1:0] s_tdata = '0;
  logic              s_tvalid = 1'b0;
  logic              s_tlast = 1'b0;
  logic              s_tready, done_o, fail_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  stream_seq_checker #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_stream_seq_checker (
    .clk(clk), .rst(rst), .arm_i(arm_i), .pkt_len_i(pkt_len_i),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
    .s_tready(s_tready), .done_o(done_o), .fail_o(fail_o)
  );

  // behavioural reference
  bit      m_armed, m_done, m_fail;
  longint  m_idx, m_len;

  always @(posedge clk) begin
    if (rst) begin
      m_armed <= 0; m_done <= 0; m_fail <= 0; m_idx <= 0; m_len <= 0;
    end else begin
      m_done <= 0;
      if (arm_i && pkt_len_i != 0) begin
        m_armed <= 1; m_idx <= 0; m_len <= longint'(pkt_len_i); m_fail <= 0;
      end else if (s_tvalid && m_armed) begin
        if (s_tdata != 64'(m_idx) || s_tlast != (m_idx == m_len - 1)) m_fail <= 1;
        if (m_idx == m_len - 1) begin
          m_armed <= 0; m_done <= 1;
        end
        m_idx <= m_idx + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2/R7 model s_tready", s_tready, m_armed);
      chk("R8 model done_o", done_o, m_done);
      chk("R3 model fail_o", fail_o, m_fail);
    end
  end

  task automatic arm(input int len);
    arm_i = 1; pkt_len_i = LEN_W'(len);
    @(negedge clk);
    arm_i = 0;
  endtask

  task automatic beat(input longint d, input bit l);
    s_tvalid = 1; s_tdata = 64'(d); s_tlast = l;
    @(negedge clk);
    s_tvalid = 0; s_tlast = 0;
  endtask

  task automatic idle(input int n);
    s_tvalid = 0; s_tlast = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1
    chk("R1 ready after reset", s_tready, 0);
    chk("R1 done after reset", done_o, 0);
    chk("R1 fail after reset", fail_o, 0);

    // R2 zero-length arm ignored
    arm(0);
    chk("R2 zero arm ready", s_tready, 0);
    // R2 nonzero arm
    arm(4);
    chk("R2 arm ready", s_tready, 1);

    // R3/R4 good packet with idle gaps
    beat(0, 0); idle(2); beat(1, 0); idle(1); beat(2, 0);
    chk("R4 no fail across idles", fail_o, 0);
    beat(3, 1);
    chk("R8 done after final", done_o, 1);
    chk("R7 ready dropped", s_tready, 0);
    chk("R3 good packet no fail", fail_o, 0);
    beat(4, 0);
    chk("R8 done single cycle", done_o, 0);
    chk("R7 beat after end ignored", fail_o, 0);
    idle(1);

    // R3 data mismatch, R9 sticky then cleared
    arm(3);
    beat(0, 0); beat(5, 0);
    chk("R3 mismatch sets fail", fail_o, 1);
    beat(2, 1);
    chk("R8 done on failed packet", done_o, 1);
    idle(3);
    chk("R9 fail sticky", fail_o, 1);
    arm(0);
    chk("R2 zero arm keeps fail", fail_o, 1);
    arm(3);
    chk("R9 arm clears fail", fail_o, 0);

    // R5 early tlast
    beat(0, 0); beat(1, 1);
    chk("R5 early tlast fails", fail_o, 1);
    chk("R5 packet continues", s_tready, 1);
    beat(2, 1);
    idle(1);

    // R6 missing tlast
    arm(3);
    beat(0, 0); beat(1, 0); beat(2, 0);
    chk("R6 missing tlast fails", fail_o, 1);
    chk("R6 packet still ends", s_tready, 0);
    idle(1);

    // R10 single beat
    arm(1);
    beat(0, 1);
    chk("R10 single beat done", done_o, 1);
    chk("R10 single beat ok", fail_o, 0);
    arm(1);
    beat(0, 0);
    chk("R10 single beat without tlast fails", fail_o, 1);
    idle(1);

    // R11 restart mid-packet, same-cycle beat discarded
    arm(4);
    beat(0, 0); beat(1, 0);
    s_tvalid = 1; s_tdata = 64'd2; s_tlast = 0;
    arm(2);
    s_tvalid = 0;
    beat(0, 0); beat(1, 1);
    chk("R11 restart completes", done_o, 1);
    chk("R11 restart no fail", fail_o, 0);
    idle(1);

    // R3 longest packet
    arm(255);
    for (int i = 0; i < 255; i++) begin
      beat(i, i == 254);
      if (i % 7 == 3) idle(1);
    end
    chk("R3 long packet done", done_o, 1);
    chk("R3 long packet ok", fail_o, 0);
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule